// File: doc/BRIEF.md
# Skew-Tolerant Four-Lane Bit-Interleaving Multiplexer

This block takes four lanes, each a one-bit stream at a quarter of the line rate, and merges them into one line-rate serial stream. It sends one bit from each lane in turn. The lanes do not share a common phase. Each lane drives its own bit strobe, and that strobe can sit anywhere relative to the common read strobe. A small elastic store on each lane re-times the lane onto the common strobe, so a lane can lead or lag by a few bit periods without breaking the interleave.

The model runs on a single line-rate clock. Clock enables stand in for the slower domains. Each lane marks the cycle that carries a new bit with its `lane_valid` bit. `ref_stb` marks the common read instant.

There is no back-pressure anywhere:
- The inputs have no ready signal. An asserted `lane_valid` is always written into that lane's store.
- The serial output has no ready signal. The line cannot stall, so `ser_valid` only marks the cycles that carry data.

A lane whose write and read positions would meet is recovered on its own. The block re-centres that lane's store and reports the event on `lane_slip`.

Store depth is set by the parameter `DEPTH`, and `HALF` below means `DEPTH/2`. With the default depth of 10, the store rides out about ±4 lane bits of drift. At the nominal rates this is roughly ±7.5 ns.

Top module: `lane_interleave_mux`

## Requirements
- R1: Each group on `ser_bit` holds four bits on four consecutive cycles, in lane order: lane 0 first, then lanes 1, 2 and 3. Lane k's bits come out in the order that lane wrote them.
- R2: An accepted `ref_stb` at a clock edge places that group's lane-0 bit on `ser_bit`, with `ser_valid` high, right after that same edge.
- R3: During and after reset, `ser_valid` and `lane_slip` are low. Each store starts with its write position `HALF` entries ahead of its read position, over zeroed contents. So the first `HALF` groups carry 0 for every lane, and a lane's first written bit appears in group number `HALF`, counting groups from 0.
- R4: A lane that writes exactly once per read period keeps its data intact and never slips. This holds at any fixed phase relative to `ref_stb`, and with a start up to `HALF-2` periods after the other lanes.
- R5: A lane that never writes raises its `lane_slip` bit for exactly one cycle at every `HALF`-th accepted `ref_stb`. After a slip, the store's write-to-read distance is `HALF` again. Its bits on `ser_bit` stay 0.
- R6: A lane that writes faster than it is read eventually slips. Lanes that write at the correct rate do not slip, and their data stays correct.
- R7: A `ref_stb` that arrives while a group is still being sent, before its last slot, is ignored. No store is read and the running group is unchanged.
- R8: If no `ref_stb` is accepted at the edge that sends a group's last slot, `ser_valid` falls one cycle after that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_valid | input | LANES | Per-lane write strobe; the bit on `lane_bit` is stored when high |
| lane_bit | input | LANES | Per-lane data bit |
| ref_stb | input | 1 | Common read strobe, nominally one cycle in every LANES |
| ser_valid | output | 1 | High while `ser_bit` carries a group slot |
| ser_bit | output | 1 | Interleaved serial data |
| lane_slip | output | LANES | One-cycle pulse when a lane's store was re-centred |

## Verification
The bench builds the block with its defaults: four lanes and a store depth of ten, so the reset distance is five. Lane write phases cover all four positions of the read period, and lane starts are staggered by up to three periods. This reaches the edges of the skew window without a slip, so a scoreboard can predict every serial bit from the pushed lane data. The small depth also puts the starved-lane slip on every fifth read and makes a fast lane overflow within a few dozen cycles. Both recovery paths are therefore reached in short runs.

// File: rtl/lim_pkg.sv
package lim_pkg;

  localparam int LIM_LANES_DEF = 4;
  localparam int LIM_DEPTH_DEF = 10;

  // modular add on ring positions
  function automatic int wrap_add(input int pos, input int delta, input int ring);
    return (pos + delta) % ring;
  endfunction

endpackage

// File: rtl/lane_elastic_store.sv
module lane_elastic_store
  import lim_pkg::*;
#(
  parameter int DEPTH = LIM_DEPTH_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic rd_en,
  output logic rd_bit,
  output logic slip
);

  localparam int AW   = (DEPTH <= 2) ? 1 : $clog2(DEPTH);
  localparam int HALF = DEPTH / 2;

  logic [DEPTH-1:0] store_q;
  logic [AW-1:0]    wpos_q, rpos_q;
  logic [AW-1:0]    wpos_n, rpos_n, rpos_fix;
  logic             meet;
  logic [AW-1:0]    gap_now;

  assign wpos_n   = wr_en ? AW'(wrap_add(int'(wpos_q), 1, DEPTH)) : wpos_q;
  assign rpos_n   = rd_en ? AW'(wrap_add(int'(rpos_q), 1, DEPTH)) : rpos_q;
  assign meet     = (wr_en || rd_en) && (wpos_n == rpos_n);
  assign rpos_fix = AW'(wrap_add(int'(wpos_n), DEPTH - HALF, DEPTH));
  assign rd_bit   = store_q[rpos_q];
  assign gap_now  = AW'(wrap_add(int'(wpos_q), DEPTH - int'(rpos_q), DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      store_q <= '0;
      wpos_q  <= AW'(HALF);
      rpos_q  <= '0;
      slip    <= 1'b0;
    end else begin
      if (wr_en) store_q[wpos_q] <= wr_bit;
      wpos_q <= wpos_n;
      rpos_q <= meet ? rpos_fix : rpos_n;
      slip   <= meet;
    end
  end

  // R4: the two positions never sit on the same entry
  a_r4_no_meet: assert property (@(posedge clk) disable iff (!rst_n)
    wpos_q != rpos_q);

  // R5: a slip leaves the store centred again
  a_r5_recentred: assert property (@(posedge clk) disable iff (!rst_n)
    slip |-> (gap_now == AW'(HALF)));

endmodule

// File: rtl/group_serializer.sv
module group_serializer
  import lim_pkg::*;
#(
  parameter int LANES = LIM_LANES_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_stb,
  input  logic [LANES-1:0] par_in,
  output logic             pop,
  output logic             ser_valid,
  output logic             ser_bit
);

  localparam int CW = (LANES <= 2) ? 1 : $clog2(LANES);
  localparam logic [CW-1:0] LAST = CW'(LANES - 1);

  logic [LANES-1:0] hold_q;
  logic [CW-1:0]    slot_q, slot_nx;
  logic             busy_q;

  assign slot_nx   = CW'(slot_q + 1'b1);
  assign pop       = ref_stb && (!busy_q || slot_q == LAST);
  assign ser_valid = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q  <= '0;
      slot_q  <= '0;
      busy_q  <= 1'b0;
      ser_bit <= 1'b0;
    end else if (pop) begin
      hold_q  <= par_in;
      slot_q  <= '0;
      busy_q  <= 1'b1;
      ser_bit <= par_in[0];
    end else if (busy_q) begin
      if (slot_q == LAST) begin
        busy_q <= 1'b0;
      end else begin
        slot_q  <= slot_nx;
        ser_bit <= hold_q[slot_nx];
      end
    end
  end

  // R1: a fresh run always begins on lane 0
  a_r1_lane0_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (slot_q == '0));

  // R7: an early strobe does not restart the group
  a_r7_early_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_stb && busy_q && slot_q != LAST) |=> (slot_q == CW'($past(slot_q) + 1'b1)));

  // R8: output goes idle after the last slot without a new strobe
  a_r8_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && slot_q == LAST && !ref_stb) |=> !ser_valid);

endmodule

// File: rtl/lane_interleave_mux.sv
module lane_interleave_mux
  import lim_pkg::*;
#(
  parameter int LANES = LIM_LANES_DEF,
  parameter int DEPTH = LIM_DEPTH_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] lane_valid,
  input  logic [LANES-1:0] lane_bit,
  input  logic             ref_stb,
  output logic             ser_valid,
  output logic             ser_bit,
  output logic [LANES-1:0] lane_slip
);

  logic [LANES-1:0] rd_bits;
  logic             pop;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_elastic_store #(.DEPTH(DEPTH)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (lane_valid[g]),
      .wr_bit (lane_bit[g]),
      .rd_en  (pop),
      .rd_bit (rd_bits[g]),
      .slip   (lane_slip[g])
    );
  end

  group_serializer #(.LANES(LANES)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_stb   (ref_stb),
    .par_in    (rd_bits),
    .pop       (pop),
    .ser_valid (ser_valid),
    .ser_bit   (ser_bit)
  );

  // R3: nothing is reported in the cycle after reset
  a_r3_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!ser_valid && lane_slip == '0));

endmodule

// File: tb/lane_interleave_mux_test.sv
module lane_interleave_mux_test;

  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4;
  localparam int DEPTH = 10;
  localparam int HALF  = DEPTH / 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [LANES-1:0] lane_valid = '0;
  logic [LANES-1:0] lane_bit = '0;
  logic             ref_stb = 1'b0;
  logic             ser_valid, ser_bit;
  logic [LANES-1:0] lane_slip;

  lane_interleave_mux #(.LANES(LANES), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .lane_valid(lane_valid), .lane_bit(lane_bit),
    .ref_stb(ref_stb), .ser_valid(ser_valid), .ser_bit(ser_bit), .lane_slip(lane_slip)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  bit       expq [LANES][$];
  int       phase [LANES];
  int       start [LANES];
  int       mode  [LANES];   // 0 steady, 1 starved, 2 fast
  bit       seen_slip [LANES];
  logic [7:0] lfsr [LANES];
  int checks = 0, fails = 0;
  int slot, since, acc, grp, ph;
  bit prev_ref, ref_run, extra_en;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; lane_valid = '0; lane_bit = '0; ref_stb = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      expq[l].delete();
      for (int k = 0; k < HALF; k++) expq[l].push_back(1'b0);
      lfsr[l] = 8'h1d + 8'(l * 37);
    end
    slot = 0; since = 99; acc = 0; grp = 0; ph = 0; prev_ref = 0;
    repeat (3) @(negedge clk);
    chk(ser_valid == 1'b0, "R3 valid in reset", int'(ser_valid), 0);
    chk(lane_slip == '0, "R3 slip in reset", int'(lane_slip), 0);
    rst_n = 1'b1;
  endtask

  task automatic step();
    bit e, v;
    int l;
    @(negedge clk);
    // observe the edge just passed
    if (prev_ref) begin acc++; since = 0; end
    else if (since < 99) since++;
    chk(ser_valid == (since <= LANES - 1), since == 0 ? "R2 valid" : "R8 valid",
        int'(ser_valid), int'(since <= LANES - 1));
    if (prev_ref) chk(slot % LANES == 0, "R2 lane0 slot", slot % LANES, 0);
    if (ser_valid) begin
      l = slot % LANES;
      slot++;
      if (mode[l] == 1) begin
        chk(ser_bit == 1'b0, "R5 starved data", int'(ser_bit), 0);
      end else if (mode[l] == 0) begin
        if (expq[l].size() == 0) chk(1'b0, "R4 queue empty", 0, 1);
        else begin
          e = expq[l].pop_front();
          chk(ser_bit == e, slot <= HALF * LANES ? "R3 reset data" : "R1 R4 R7 data",
              int'(ser_bit), int'(e));
        end
      end
    end
    for (int k = 0; k < LANES; k++) begin
      if (mode[k] == 0) chk(lane_slip[k] == 1'b0, "R4 R6 no slip", int'(lane_slip[k]), 0);
      else if (mode[k] == 1) begin
        e = prev_ref && (acc % HALF == 0);
        chk(lane_slip[k] == e, "R5 slip timing", int'(lane_slip[k]), int'(e));
      end else if (lane_slip[k]) seen_slip[k] = 1;
    end
    // drive the next edge
    prev_ref = ref_run && (ph == 0);
    ref_stb  = prev_ref || (extra_en && ph == 2 && (grp % 8 == 3));
    for (int k = 0; k < LANES; k++) begin
      v = 0;
      if (mode[k] == 0) v = (ph == phase[k]) && (grp >= start[k]);
      else if (mode[k] == 2) v = (ph % 2 == 0);
      lane_valid[k] = v;
      lane_bit[k] = lfsr[k][0];
      if (v) begin
        if (mode[k] == 0) expq[k].push_back(lfsr[k][0]);
        lfsr[k] = {lfsr[k][6:0], lfsr[k][7] ^ lfsr[k][5] ^ lfsr[k][4] ^ lfsr[k][3]};
      end
    end
    ph++;
    if (ph == LANES) begin ph = 0; grp++; end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
    summary();
    $finish;
  end

  initial begin
    // A: each lane at its own phase, early strobes sprinkled in (R1 R2 R3 R4 R7)
    for (int l = 0; l < LANES; l++) begin mode[l] = 0; phase[l] = l; start[l] = 0; end
    ref_run = 1; extra_en = 1;
    do_reset();
    repeat (800) step();

    // B: random phases and staggered starts, then a strobe gap (R4 R8)
    for (int l = 0; l < LANES; l++) begin
      phase[l] = $urandom_range(LANES - 1);
      start[l] = $urandom_range(HALF - 2);
    end
    extra_en = 0;
    do_reset();
    repeat (800) step();
    ref_run = 0;
    repeat (8) step();
    ref_run = 1;
    repeat (200) step();

    // C: lane 3 never writes (R5)
    for (int l = 0; l < LANES; l++) begin phase[l] = l; start[l] = 0; end
    mode[3] = 1;
    do_reset();
    repeat (200) step();

    // D: lane 1 writes twice per period (R6)
    mode[3] = 0; mode[1] = 2;
    for (int l = 0; l < LANES; l++) seen_slip[l] = 0;
    do_reset();
    repeat (60) step();
    chk(seen_slip[1], "R6 fast lane slipped", int'(seen_slip[1]), 1);

    summary();
    $finish;
  end

endmodule